// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Front End

This block is the front end of a simple five-stage pipeline. It holds the fetch program counter, a small instruction store and the fetch/decode pipeline register. It also holds a register-file model that supplies two operands to the instruction in decode. A branch-if-equal is settled while it is still in decode. A dedicated equality comparator looks at the two register reads, and a dedicated adder forms a target for every decoded word. On a taken branch, fetch is steered to the target at the clock edge that ends the decode cycle.

At that edge only one wrong-path word has been fetched. In the default mode that word enters decode as an empty bubble, so a taken branch costs one cycle. With the `DELAYED` parameter set, the word after the branch is kept and runs normally, so a taken branch costs no cycle. The block ends at decode. A trace port reports, each cycle, which instruction is leaving decode, so a downstream stage or a bench can follow the retired stream. Two write ports fill the instruction store and the register model.

Top module: `early_branch_unit`

## Requirements
- R1: While `rst` is high, the decode register is empty and `trace_valid` is 0. After `rst` falls, the first instruction to reach decode is the one at address 0.
- R2: Without a redirect, fetch moves forward by 4 bytes each cycle. `trace_pc` then steps by 4 on consecutive cycles, with `trace_valid` high throughout.
- R3: `br_taken` is high in the decode cycle of a word only under three conditions: `trace_valid` is 1, bits 31:26 of the word are 000100 (branch-if-equal), and the registers named by bits 25:21 and 20:16 hold equal values.
- R4: `br_target` is computed for every word in decode. Its value is the word's address plus 4, plus the sign-extended 16-bit field in bits 15:0 multiplied by 4. For example, a branch at 40 with field 7 targets 72, and with field -1 it targets 40. Two cycles after a taken decision, the target address is the one leaving decode.
- R5: A branch-if-equal whose operands differ causes no stall and no bubble. The word at the branch address plus 4 follows it directly.
- R6: With `DELAYED`=0, the word fetched behind a taken branch never appears on the trace. `trace_valid` is 0 for exactly one cycle, and then the target follows.
- R7: With `DELAYED`=1, the word behind a taken branch leaves decode in the next cycle. The target follows it directly, so no cycle is lost.
- R8: A word whose bits 31:26 are not 000100 never redirects fetch, even when the two registers it names hold equal values.
- R9: Register 0 always reads as zero, and writes to it are dropped. A branch on register 0 against a register holding 0 is therefore taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | $clog2(IMEM_WORDS) | Word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| rf_we | input | 1 | Register model write enable |
| rf_waddr | input | $clog2(NREGS) | Register to write |
| rf_wdata | input | XLEN | Register value |
| br_taken | output | 1 | Taken decision for the word in decode |
| br_target | output | 32 | Target address formed for the word in decode |
| trace_valid | output | 1 | A real instruction is leaving decode this cycle |
| trace_pc | output | 32 | Address of the instruction leaving decode |
| trace_instr | output | 32 | Encoding of the instruction leaving decode |

## Verification
The hardest states to reach are a taken branch whose target is itself, or the word right after it. There the bubble or the kept slot overlaps the next redirect, and the same address shows up twice in a row on the trace. The stimulus table places one branch at address 40 and surrounds it with zero words. It sets its operands through the register write port, and uses field values -1 and 0 to force those overlaps. The table also covers a backward target that loops back onto the branch. Each row runs against a bubble-mode and a delayed-mode instance together, and the expected trace comes from a small per-mode model.

// File: rtl/erb_pkg.sv
package erb_pkg;

    localparam logic [5:0]  OP_BEQ    = 6'b000100;
    localparam logic [31:0] WORD_NOP  = 32'h0000_0000;
    localparam logic [31:0] PC_STEP   = 32'd4;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
    } instr_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] pc;
        instr_t      ins;
    } fd_reg_t;

    typedef struct packed {
        logic        taken;
        logic [31:0] target;
    } redirect_t;

    function automatic logic [31:0] word_offset(input logic [15:0] imm);
        return {{14{imm[15]}}, imm, 2'b00};
    endfunction

endpackage

// File: rtl/erb_fetch.sv
module erb_fetch
    import erb_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter bit DELAYED    = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [31:0]                   imem_wdata,
    input  redirect_t                     redir,
    output fd_reg_t                       fd
);
    localparam int AW = $clog2(IMEM_WORDS);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] pc_q;
    logic [31:0] fetch_word;
    logic        squash;
    fd_reg_t     fd_q;

    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    assign fetch_word = imem[pc_q[AW+1:2]];

    // The variant decides whether the word behind a taken branch survives.
    generate
        if (DELAYED) begin : g_keep_slot
            assign squash = 1'b0;
        end else begin : g_drop_slot
            assign squash = redir.taken;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)              pc_q <= '0;
        else if (redir.taken) pc_q <= redir.target;
        else                  pc_q <= pc_q + PC_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst || squash) begin
            fd_q <= '0;
        end else begin
            fd_q.valid <= 1'b1;
            fd_q.pc    <= pc_q;
            fd_q.ins   <= instr_t'(fetch_word);
        end
    end

    assign fd = fd_q;
endmodule

// File: rtl/erb_regfile.sv
module erb_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [XLEN-1:0]          rdata_a,
    output logic [XLEN-1:0]          rdata_b
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/erb_resolve.sv
module erb_resolve
    import erb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            dec_valid,
    input  logic [5:0]      dec_op,
    input  logic [15:0]     dec_imm,
    input  logic [31:0]     dec_pc,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output redirect_t       redir
);
    logic operands_equal;
    logic is_beq;

    assign operands_equal = (opnd_a == opnd_b);
    assign is_beq         = (dec_op == OP_BEQ);

    // The adder runs for every decoded word; its sum is simply unused off a branch.
    assign redir.target = dec_pc + PC_STEP + word_offset(dec_imm);
    assign redir.taken  = dec_valid && is_beq && operands_equal;
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
    import erb_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int NREGS      = 32,
    parameter int XLEN       = 32,
    parameter bit DELAYED    = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [31:0]                   imem_wdata,
    input  logic                          rf_we,
    input  logic [$clog2(NREGS)-1:0]      rf_waddr,
    input  logic [XLEN-1:0]               rf_wdata,
    output logic                          br_taken,
    output logic [31:0]                   br_target,
    output logic                          trace_valid,
    output logic [31:0]                   trace_pc,
    output logic [31:0]                   trace_instr
);
    localparam int RF_AW = $clog2(NREGS);

    fd_reg_t         fd;
    redirect_t       redir;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;

    erb_fetch #(
        .IMEM_WORDS (IMEM_WORDS),
        .DELAYED    (DELAYED)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .redir      (redir),
        .fd         (fd)
    );

    erb_regfile #(
        .NREGS (NREGS),
        .XLEN  (XLEN)
    ) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fd.ins.rs[RF_AW-1:0]),
        .raddr_b (fd.ins.rt[RF_AW-1:0]),
        .rdata_a (opnd_a),
        .rdata_b (opnd_b)
    );

    erb_resolve #(
        .XLEN (XLEN)
    ) u_resolve (
        .dec_valid (fd.valid),
        .dec_op    (fd.ins.op),
        .dec_imm   (fd.ins.imm),
        .dec_pc    (fd.pc),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .redir     (redir)
    );

    assign br_taken    = redir.taken;
    assign br_target   = redir.target;
    assign trace_valid = fd.valid;
    assign trace_pc    = fd.pc;
    assign trace_instr = fd.ins;
endmodule

// File: rtl/erb_checker.sv
module erb_checker
    import erb_pkg::*;
#(
    parameter bit DELAYED = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        br_taken,
    input logic [31:0] br_target,
    input logic        trace_valid,
    input logic [31:0] trace_pc,
    input logic [5:0]  dec_op
);
    // R1: a reset cycle leaves decode empty
    a_r1_empty_after_reset: assert property (@(posedge clk)
        rst |=> !trace_valid);

    // R3 and R8: only a valid branch-if-equal opcode may redirect
    a_r3_taken_only_beq: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (trace_valid && dec_op == OP_BEQ));

    // R4: two cycles after a taken decision the target leaves decode
    a_r4_target_arrives: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> ##1 (trace_valid && trace_pc == $past(br_target, 2)));

    // R5 and R2: a non-redirecting word is followed by its successor
    a_r5_sequential: assert property (@(posedge clk) disable iff (rst)
        (trace_valid && !br_taken && !(DELAYED && $past(br_taken)))
        |=> (trace_valid && trace_pc == $past(trace_pc) + 32'd4));

    // R6: bubble mode leaves one empty decode cycle
    a_r6_one_bubble: assert property (@(posedge clk) disable iff (rst)
        (!DELAYED && br_taken) |=> !trace_valid);

    // R7: delayed mode keeps the slot word
    a_r7_slot_kept: assert property (@(posedge clk) disable iff (rst)
        (DELAYED && br_taken) |=> (trace_valid && trace_pc == $past(trace_pc) + 32'd4));
endmodule

bind early_branch_unit erb_checker #(
    .DELAYED (DELAYED)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .trace_valid (trace_valid),
    .trace_pc    (trace_pc),
    .dec_op      (trace_instr[31:26])
);

// File: tb/sim_early_branch_unit.sv
`timescale 1ns/1ps
module sim_early_branch_unit;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [31:0] va;
        logic [31:0] vb;
        logic [15:0] off;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'h04, 5'd1, 5'd2, 32'd5,          32'd5,          16'd7},
        '{6'h04, 5'd1, 5'd2, 32'd5,          32'd6,          16'd7},
        '{6'h04, 5'd3, 5'd4, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  16'hFFFB},
        '{6'h04, 5'd5, 5'd6, 32'h8000_0000,  32'h0,          16'd3},
        '{6'h04, 5'd0, 5'd7, 32'd123,        32'd0,          16'd9},
        '{6'h05, 5'd1, 5'd2, 32'd9,          32'd9,          16'd7},
        '{6'h04, 5'd1, 5'd2, 32'd7,          32'd7,          16'd0},
        '{6'h04, 5'd8, 5'd9, 32'd1,          32'd1,          16'hFFFF},
        '{6'h04, 5'd1, 5'd2, 32'd1,          32'd1,          16'd50}
    };
    localparam int BR_WORD = 10;
    localparam int RUN_CYC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic        rf_we = 1'b0;
    logic [4:0]  rf_waddr = '0;
    logic [31:0] rf_wdata = '0;

    logic        tk0, tk1, tv0, tv1;
    logic [31:0] tg0, tg1, tp0, tp1, ti0, ti1;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    early_branch_unit #(.DELAYED(1'b0)) u0 (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .br_taken(tk0), .br_target(tg0),
        .trace_valid(tv0), .trace_pc(tp0), .trace_instr(ti0));

    early_branch_unit #(.DELAYED(1'b1)) u1 (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .br_taken(tk1), .br_target(tg1),
        .trace_valid(tv1), .trace_pc(tp1), .trace_instr(ti1));

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] ra, rb, tgt, e_pc [2];
        logic        tk, cv, ctk;
        logic [31:0] cp, ctg, ci;
        int          ph [2];
        bit          after_nt [2];
        rst = 1'b1;
        for (int w = 0; w < 64; w++) begin
            imem_we    = 1'b1;
            imem_waddr = w[5:0];
            imem_wdata = (w == BR_WORD) ? {v.op, v.rs, v.rt, v.off} : 32'h0;
            @(negedge clk);
        end
        imem_we  = 1'b0;
        rf_we    = 1'b1;
        rf_waddr = v.rs; rf_wdata = v.va; @(negedge clk);
        rf_waddr = v.rt; rf_wdata = v.vb; @(negedge clk);
        rf_we    = 1'b0;
        // R1: decode stays empty while reset is held
        check(!tv0 && !tv1, "R1 reset empties decode", {30'd0, tv1, tv0}, 32'd0);
        ra  = (v.rs == 5'd0) ? 32'd0 : v.va;
        rb  = (v.rt == 5'd0) ? 32'd0 : v.vb;
        tk  = (v.op == 6'h04) && (ra == rb);
        tgt = 32'd44 + {{14{v.off[15]}}, v.off, 2'b00};
        for (int d = 0; d < 2; d++) begin
            e_pc[d] = 32'd0; ph[d] = 0; after_nt[d] = 1'b0;
        end
        rst = 1'b0;
        for (int k = 0; k < RUN_CYC; k++) begin
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin
                cv  = d ? tv1 : tv0;
                cp  = d ? tp1 : tp0;
                ctk = d ? tk1 : tk0;
                ctg = d ? tg1 : tg0;
                ci  = d ? ti1 : ti0;
                if (ph[d] == 1) begin
                    if (d == 1)
                        check(cv && cp == 32'd44, "R7 delay slot kept", cp, 32'd44);
                    else
                        check(!cv, "R6 slot squashed to bubble", {31'd0, cv}, 32'd0);
                    e_pc[d] = tgt;
                    ph[d]   = 2;
                end else begin
                    check(cv && cp == e_pc[d],
                          (ph[d] == 2) ? "R4 target reached" :
                          after_nt[d]  ? "R5 no stall on not-taken" :
                          (k == 0)     ? "R1 first fetch from 0" : "R2 sequential step",
                          cp, e_pc[d]);
                    after_nt[d] = 1'b0;
                    if (e_pc[d] == 32'd40) begin
                        check(ctk == tk, "R3 R8 R9 branch decision", {31'd0, ctk}, {31'd0, tk});
                        check(ctg == tgt, "R4 target value", ctg, tgt);
                        check(ci == {v.op, v.rs, v.rt, v.off}, "R2 word in decode", ci,
                              {v.op, v.rs, v.rt, v.off});
                    end else begin
                        check(!ctk, "R3 no redirect off the branch", {31'd0, ctk}, 32'd0);
                    end
                    if (e_pc[d] == 32'd40 && tk) begin
                        ph[d] = 1;
                    end else begin
                        after_nt[d] = (e_pc[d] == 32'd40);
                        e_pc[d] = e_pc[d] + 32'd4;
                        ph[d]   = 0;
                    end
                end
            end
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state before any load
        check(!tv0 && !tv1 && !tk0 && !tk1, "R1 initial reset state",
              {28'd0, tk1, tk0, tv1, tv0}, 32'd0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R1: a mid-run reset empties decode at the next edge
        rst = 1'b1;
        @(negedge clk);
        check(!tv0 && !tv1, "R1 mid-run reset", {30'd0, tv1, tv0}, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule